// File: doc/BRIEF.md
# Memory Protection Region Checker

This block checks every bus access against a set of programmable address windows. Each window has a base, a power-of-two size code, an access-permission code, an execute-never flag and a memory-type field. The memory-type field is only stored. When checking is switched on, each access is either allowed or faulted in the same cycle. A faulting access sets a sticky cause flag. The address of the first unacknowledged fault is also held for software.

Software configures the block through a small word-addressed register port. Control, fault status, fault address and region select each have one offset. Four identical base/attribute pairs follow them, so a run of eight consecutive writes can set up four regions. The access port carries an address together with write and instruction-fetch qualifiers. It returns complementary allow and fault strobes.

Top module: `mpu_region_guard`

## Requirements
- R1: After reset, control, fault status, fault address and region select read 0 and every region is disabled. While checking is off, every valid access is allowed.
- R2: The control register at offset 0 stores bit 0, which enables checking. While that bit is 0, acc_fault stays low.
- R3: A write to a base register (offsets 4, 6, 8, 10) stores bits 31:5 as the region base. If bit 4 is 1, bits 3:0 choose the region and are also copied into the select register at offset 3. If bit 4 is 0, the region currently selected is written. A read returns {base, 0, select}.
- R4: A write to an attribute register (offsets 5, 7, 9, 11) goes to the selected region and keeps only the mask 0x173F_003F: bit 0 enable, bits 5:1 size code, bits 21:16 memory type, bits 26:24 permission, bit 28 execute-never. A read returns the kept value.
- R5: The four base/attribute pairs at offsets 4/5, 6/7, 8/9 and 10/11 behave identically.
- R6: A region with enable set and size code N of 4 or more covers the naturally aligned 2^(N+1)-byte window that contains its base. Base bits below bit N+1 are ignored. A size code below 4 matches nothing.
- R7: When several enabled regions match, the highest-numbered one decides.
- R8: While checking is on, an access that matches no region faults.
- R9: Permission codes 1, 2 and 3 allow read, write and fetch. Codes 5, 6 and 7 allow read and fetch but fault on writes. Codes 0 and 4 fault on every access.
- R10: A fetch from a region with execute-never set faults, whatever the permission code. A fetch is judged as a fetch even when acc_write is also high.
- R11: Fault status (offset 1) sets bit 0 for a faulting fetch and bit 1 for a faulting data access. The bits stay set until a 1 is written to them.
- R12: Status bit 7 flags a valid fault address (offset 2). The address is captured on a fault only while bit 7 is clear or being cleared in the same cycle. Writing 1 to bit 7 re-arms the capture.
- R13: Offsets 12 to 15 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_allow | output | 1 | Access permitted |
| acc_fault | output | 1 | Access violates the region rules |

## Verification
The decision path is swept with every region's base, last byte, first byte past the end and a point below the base. Each point is tried as a read, a write and a fetch. The read/write/fetch split separates permission codes from execute-never. Boundary points separate correct size decoding from off-by-one masks, and a misaligned base shows that low base bits are ignored. Overlapping regions and an undersized region show the priority order and the minimum size rule. Paired faults without an intervening clear separate sticky flags and the single-capture address from an always-updating one.

// File: rtl/mpu_pkg.sv
`timescale 1ns/1ps
package mpu_pkg;
   localparam int unsigned REG_DW     = 32;
   localparam int unsigned SEL_W      = 4;
   localparam int unsigned BASE_LSB   = 5;
   localparam int unsigned SZ_LSB     = 1;
   localparam int unsigned SZ_W       = 5;
   localparam int unsigned AP_LSB     = 24;
   localparam int unsigned XN_BIT     = 28;
   localparam int unsigned MIN_SZ     = 4;
   localparam logic [31:0] ATTR_KEEP  = 32'h173F_003F;

   localparam logic [3:0] OFS_CTRL  = 4'd0;
   localparam logic [3:0] OFS_STAT  = 4'd1;
   localparam logic [3:0] OFS_FADDR = 4'd2;
   localparam logic [3:0] OFS_SEL   = 4'd3;
   localparam logic [3:0] PAIR_LO   = 4'd4;
   localparam logic [3:0] PAIR_HI   = 4'd11;

   localparam int unsigned ST_INSN = 0;
   localparam int unsigned ST_DATA = 1;
   localparam int unsigned ST_AV   = 7;

   typedef struct packed {
      logic rd_ok;
      logic wr_ok;
   } perm_t;

   function automatic perm_t decode_ap(input logic [2:0] ap);
      perm_t p;
      case (ap)
         3'd1, 3'd2, 3'd3: p = '{rd_ok: 1'b1, wr_ok: 1'b1};
         3'd5, 3'd6, 3'd7: p = '{rd_ok: 1'b1, wr_ok: 1'b0};
         default:          p = '{rd_ok: 1'b0, wr_ok: 1'b0};
      endcase
      return p;
   endfunction

   function automatic logic in_pair(input logic [3:0] a);
      return (a >= PAIR_LO) && (a <= PAIR_HI);
   endfunction
endpackage

// File: rtl/mpu_cfg_regs.sv
`timescale 1ns/1ps
module mpu_cfg_regs import mpu_pkg::*; #(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned ADDR_W      = 32
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr,
   input  logic [3:0]                             addr,
   input  logic [REG_DW-1:0]                      wdata,
   output logic                                   en,
   output logic [SEL_W-1:0]                       sel,
   output logic [NUM_REGIONS-1:0][ADDR_W-BASE_LSB-1:0] rgn_base,
   output logic [NUM_REGIONS-1:0][REG_DW-1:0]     rgn_attr
);
   localparam int unsigned BASE_W = ADDR_W - BASE_LSB;

   logic             base_wr, attr_wr;
   logic [SEL_W-1:0] tgt;

   assign base_wr = wr && in_pair(addr) && !addr[0];
   assign attr_wr = wr && in_pair(addr) &&  addr[0];
   assign tgt     = (base_wr && wdata[4]) ? wdata[SEL_W-1:0] : sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en  <= 1'b0;
         sel <= '0;
      end else begin
         if (wr && addr == OFS_CTRL) en <= wdata[0];
         if (wr && addr == OFS_SEL) sel <= wdata[SEL_W-1:0];
         else if (base_wr && wdata[4]) sel <= wdata[SEL_W-1:0];
      end
   end

   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rgn_base[i] <= '0;
            rgn_attr[i] <= '0;
         end else begin
            if (base_wr && tgt == SEL_W'(i))
               rgn_base[i] <= wdata[ADDR_W-1:BASE_LSB];
            if (attr_wr && sel == SEL_W'(i))
               rgn_attr[i] <= wdata & ATTR_KEEP;
         end
      end
   end

   initial begin
      assert (BASE_W >= 1) else $error("address too narrow for base field");
   end
endmodule

// File: rtl/mpu_region_match.sv
`timescale 1ns/1ps
module mpu_region_match import mpu_pkg::*; #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic [ADDR_W-BASE_LSB-1:0] base,
   input  logic                       en,
   input  logic [SZ_W-1:0]            size,
   output logic                       hit
);
   logic [ADDR_W-1:0] full_base;
   logic [ADDR_W-1:0] keep;

   assign full_base = {base, {BASE_LSB{1'b0}}};

   always_comb begin
      for (int b = 0; b < ADDR_W; b++)
         keep[b] = (b > int'(size));
   end

   assign hit = en && (size >= SZ_W'(MIN_SZ)) && (((addr ^ full_base) & keep) == '0);
endmodule

// File: rtl/mpu_fault_log.sv
`timescale 1ns/1ps
module mpu_fault_log #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_insn,
   input  logic              clr_data,
   input  logic              clr_av,
   input  logic              flt_insn,
   input  logic              flt_data,
   input  logic [ADDR_W-1:0] flt_addr,
   output logic              st_insn,
   output logic              st_data,
   output logic              st_av,
   output logic [ADDR_W-1:0] faddr
);
   logic flt;
   assign flt = flt_insn || flt_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_insn <= 1'b0;
         st_data <= 1'b0;
         st_av   <= 1'b0;
         faddr   <= '0;
      end else begin
         st_insn <= (st_insn && !clr_insn) || flt_insn;
         st_data <= (st_data && !clr_data) || flt_data;
         st_av   <= (st_av   && !clr_av)   || flt;
         if (flt && (!st_av || clr_av)) faddr <= flt_addr;
      end
   end
endmodule

// File: rtl/mpu_region_guard.sv
`timescale 1ns/1ps
module mpu_region_guard import mpu_pkg::*; #(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned ADDR_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [3:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              acc_fetch,
   output logic              acc_allow,
   output logic              acc_fault
);
   localparam int unsigned BASE_W = ADDR_W - BASE_LSB;

   logic                                ctl_en;
   logic [SEL_W-1:0]                    sel_q;
   logic [NUM_REGIONS-1:0][BASE_W-1:0]  rgn_base;
   logic [NUM_REGIONS-1:0][REG_DW-1:0]  rgn_attr;
   logic [NUM_REGIONS-1:0]              hit;
   logic                                hit_any, win_xn;
   logic [2:0]                          win_ap;
   perm_t                               perm;
   logic                                flt_insn, flt_data, chk_on;
   logic                                stat_wr, stat_clr_av;
   logic                                st_insn, st_data, st_av;
   logic [ADDR_W-1:0]                   faddr_q;
   logic [BASE_W-1:0]                   sel_base;
   logic [REG_DW-1:0]                   sel_attr;

   mpu_cfg_regs #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
      .en(ctl_en), .sel(sel_q), .rgn_base(rgn_base), .rgn_attr(rgn_attr)
   );

   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_match
      mpu_region_match #(.ADDR_W(ADDR_W)) match_i (
         .addr(acc_addr), .base(rgn_base[i]), .en(rgn_attr[i][0]),
         .size(rgn_attr[i][SZ_LSB +: SZ_W]), .hit(hit[i])
      );
   end

   // later regions override earlier ones: highest index wins
   always_comb begin
      hit_any = 1'b0;
      win_ap  = '0;
      win_xn  = 1'b0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (hit[i]) begin
            hit_any = 1'b1;
            win_ap  = rgn_attr[i][AP_LSB +: 3];
            win_xn  = rgn_attr[i][XN_BIT];
         end
      end
   end

   assign perm     = decode_ap(win_ap);
   assign chk_on   = acc_valid && ctl_en;
   assign flt_insn = chk_on && acc_fetch &&
                     (!hit_any || !perm.rd_ok || win_xn);
   assign flt_data = chk_on && !acc_fetch &&
                     (!hit_any || (acc_write ? !perm.wr_ok : !perm.rd_ok));
   assign acc_fault = flt_insn || flt_data;
   assign acc_allow = acc_valid && !acc_fault;

   assign stat_wr     = cfg_wr && cfg_addr == OFS_STAT;
   assign stat_clr_av = stat_wr && cfg_wdata[ST_AV];

   mpu_fault_log #(.ADDR_W(ADDR_W)) log_i (
      .clk(clk), .rst_n(rst_n),
      .clr_insn(stat_wr && cfg_wdata[ST_INSN]),
      .clr_data(stat_wr && cfg_wdata[ST_DATA]),
      .clr_av(stat_clr_av),
      .flt_insn(flt_insn), .flt_data(flt_data), .flt_addr(acc_addr),
      .st_insn(st_insn), .st_data(st_data), .st_av(st_av), .faddr(faddr_q)
   );

   always_comb begin
      sel_base = '0;
      sel_attr = '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (sel_q == SEL_W'(i)) begin
            sel_base = rgn_base[i];
            sel_attr = rgn_attr[i];
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr == OFS_CTRL)       cfg_rdata = {31'b0, ctl_en};
      else if (cfg_addr == OFS_STAT)  cfg_rdata = {24'b0, st_av, 5'b0, st_data, st_insn};
      else if (cfg_addr == OFS_FADDR) cfg_rdata = REG_DW'(faddr_q);
      else if (cfg_addr == OFS_SEL)   cfg_rdata = REG_DW'(sel_q);
      else if (in_pair(cfg_addr))
         cfg_rdata = cfg_addr[0] ? sel_attr : REG_DW'({sel_base, 1'b0, sel_q});
   end

   initial begin
      assert (NUM_REGIONS >= 1 && NUM_REGIONS <= (1 << SEL_W))
         else $error("NUM_REGIONS out of range");
      assert (ADDR_W > BASE_LSB + MIN_SZ && ADDR_W <= REG_DW)
         else $error("ADDR_W out of range");
   end
endmodule

// File: rtl/mpu_region_guard_chk.sv
`timescale 1ns/1ps
module mpu_region_guard_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              acc_fetch,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_fault,
   input logic              st_insn,
   input logic              st_data,
   input logic              st_av,
   input logic              clr_av,
   input logic [ADDR_W-1:0] faddr
);
   // R2
   disabled_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !acc_fault);

   // R11
   insn_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fault && acc_fetch) |=> st_insn);

   // R11
   data_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fault && !acc_fetch) |=> st_data);

   // R12
   faddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_av && !clr_av) |=> $stable(faddr));

   // R12
   faddr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fault && !st_av) |=> (st_av && faddr == $past(acc_addr)));
endmodule

bind mpu_region_guard mpu_region_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .en(ctl_en), .acc_fetch(acc_fetch),
   .acc_addr(acc_addr), .acc_fault(acc_fault), .st_insn(st_insn),
   .st_data(st_data), .st_av(st_av), .clr_av(stat_clr_av), .faddr(faddr_q)
);

// File: tb/mpu_region_guard_tb_top.sv
`timescale 1ns/1ps
module mpu_region_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_write = 1'b0;
   logic        acc_fetch = 1'b0;
   logic        acc_allow, acc_fault;

   int errs = 0;
   int checks = 0;
   bit done = 0;

   logic [31:0] m_base [8];
   int          m_n    [8];
   logic [2:0]  m_ap   [8];
   bit          m_xn   [8];
   bit          m_en   [8];

   always #2.5 clk = ~clk;

   mpu_region_guard #(.NUM_REGIONS(8), .ADDR_W(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_write(acc_write), .acc_fetch(acc_fetch),
      .acc_allow(acc_allow), .acc_fault(acc_fault)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   function automatic logic [31:0] attr_of(input int i);
      return 32'(m_en[i]) | (32'(m_n[i]) << 1) | (32'h08 << 16) |
             (32'(m_ap[i]) << 24) | (32'(m_xn[i]) << 28);
   endfunction

   function automatic bit mdl_fault(input logic [31:0] a, input bit w, input bit f);
      int  hit = -1;
      bit  rok, wok;
      for (int i = 0; i < 8; i++) begin
         longint sz = longint'(1) << (m_n[i] + 1);
         if (m_en[i] && m_n[i] >= 4 &&
             (longint'({32'b0, a}) / sz) == (longint'({32'b0, m_base[i]}) / sz))
            hit = i;
      end
      if (hit < 0) return 1'b1;
      rok = m_ap[hit] inside {3'd1, 3'd2, 3'd3, 3'd5, 3'd6, 3'd7};
      wok = m_ap[hit] inside {3'd1, 3'd2, 3'd3};
      if (f) return !rok || m_xn[hit];
      if (w) return !wok;
      return !rok;
   endfunction

   task automatic set_rgn(input int i, input logic [31:0] b, input int n,
                          input logic [2:0] ap, input bit xn, input bit en);
      m_base[i] = b; m_n[i] = n; m_ap[i] = ap; m_xn[i] = xn; m_en[i] = en;
   endtask

   // one access, then status/address readback, then clear
   task automatic probe(input logic [31:0] a, input bit w, input bit f);
      bit          ef;
      logic [31:0] st, fa, exp_st;
      ef = mdl_fault(a, w, f);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_fetch = f;
      #1;
      // R6 R7 R8 R9 R10 decision at the port
      check({acc_fault, acc_allow} == {ef, !ef}, "R6 R7 R8 R9 R10 decision",
            {30'b0, acc_fault, acc_allow}, {30'b0, ef, !ef});
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; acc_fetch = 1'b0;
      rd(4'd1, st);
      exp_st = ef ? (f ? 32'h81 : 32'h82) : 32'h0;
      check(st == exp_st, "R11 status flags", st, exp_st);
      if (ef) begin
         rd(4'd2, fa);
         check(fa == a, "R12 fault address", fa, a);
         wr(4'd1, 32'h83);
      end
   endtask

   initial begin : wd
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      for (int i = 0; i < 8; i++) set_rgn(i, 32'h0, 0, 3'd0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd0, v); check(v == 0, "R1 control reset", v, 0);
      rd(4'd1, v); check(v == 0, "R1 status reset", v, 0);
      rd(4'd2, v); check(v == 0, "R1 fault address reset", v, 0);
      rd(4'd3, v); check(v == 0, "R1 select reset", v, 0);
      rd(4'd5, v); check(v == 0, "R1 region 0 attribute reset", v, 0);
      // R1 disabled: background write allowed
      @(negedge clk); acc_valid = 1; acc_addr = 32'h7000_0000; acc_write = 1; #1;
      check(acc_allow && !acc_fault, "R1 disabled allows", {31'b0, acc_allow}, 1);
      @(negedge clk); acc_valid = 0; acc_write = 0;
      rd(4'd1, v); check(v == 0, "R2 no status while off", v, 0);

      // R4 attribute mask on region 7 (checking is off)
      wr(4'd3, 32'd7);
      wr(4'd5, 32'hFFFF_FFFF);
      rd(4'd5, v); check(v == 32'h173F_003F, "R4 attribute mask", v, 32'h173F_003F);
      wr(4'd5, 32'h0);
      rd(4'd5, v); check(v == 0, "R4 attribute cleared", v, 0);

      set_rgn(0, 32'h0000_0000, 15, 3'd6, 1'b0, 1'b1);
      set_rgn(1, 32'h1000_0000, 14, 3'd3, 1'b1, 1'b1);
      set_rgn(2, 32'h1000_4000, 11, 3'd0, 1'b0, 1'b1);
      set_rgn(3, 32'h2000_0000,  3, 3'd3, 1'b0, 1'b1);
      set_rgn(4, 32'h3000_0100,  9, 3'd5, 1'b0, 1'b1);
      set_rgn(5, 32'h5000_0000, 12, 3'd4, 1'b0, 1'b1);
      set_rgn(6, 32'h0000_8000, 12, 3'd2, 1'b0, 1'b1);

      // R5 burst through the four alias pairs with the valid bit (R3)
      for (int i = 0; i < 4; i++) begin
         wr(4'(4 + 2 * i), m_base[i] | 32'h10 | 32'(i));
         wr(4'(5 + 2 * i), attr_of(i));
      end
      rd(4'd3, v); check(v == 3, "R3 valid bit updates select", v, 3);
      rd(4'd10, v); check(v == (m_base[3] | 32'd3), "R5 alias base readback", v, m_base[3] | 32'd3);
      rd(4'd5, v); check(v == attr_of(3), "R5 alias attribute readback", v, attr_of(3));

      // R3 select then base without valid bit
      for (int i = 4; i < 7; i++) begin
         wr(4'd3, 32'(i));
         wr(4'd4, m_base[i]);
         wr(4'd7, attr_of(i));
         if (i == 4) begin
            rd(4'd8, v);
            check(v == 32'h3000_0104, "R3 base readback with select", v, 32'h3000_0104);
         end
      end
      rd(4'd9, v); check(v == attr_of(6), "R4 attribute readback", v, attr_of(6));

      // R13 unused offsets
      wr(4'd13, 32'hFFFF_FFFF);
      rd(4'd13, v); check(v == 0, "R13 unused offset reads zero", v, 0);
      rd(4'd0, v); check(v == 0, "R13 write to unused offset ignored", v, 0);

      // R2 enable
      wr(4'd0, 32'h1);
      rd(4'd0, v); check(v == 1, "R2 control enable", v, 1);

      // sweep region boundaries with read, write, fetch
      for (int i = 0; i < 8; i++) begin
         longint      sz = longint'(1) << (m_n[i] + 1);
         logic [31:0] pts [4];
         pts[0] = m_base[i];
         pts[1] = m_base[i] + 32'(sz - 1);
         pts[2] = m_base[i] + 32'(sz);
         pts[3] = m_base[i] - 32'd32;
         for (int p = 0; p < 4; p++)
            for (int k = 0; k < 3; k++)
               probe(pts[p], k == 1, k == 2);
      end
      // R10 fetch with write also high judged as fetch (execute-never region 1)
      probe(32'h1000_0040, 1'b1, 1'b1);
      // R7 overlap: region 6 read/write inside read-only region 0
      probe(32'h0000_9000, 1'b1, 1'b0);
      // R6 undersized region 3 gives background fault
      probe(32'h2000_0004, 1'b0, 1'b0);

      // R12 second fault keeps first address; R11 sticky flags
      probe_pair();

      // R2 disable again: no fault on background
      wr(4'd0, 32'h0);
      @(negedge clk); acc_valid = 1; acc_addr = 32'h7000_0000; acc_fetch = 1; #1;
      check(!acc_fault && acc_allow, "R2 disabled no fault", {31'b0, acc_fault}, 0);
      @(negedge clk); acc_valid = 0; acc_fetch = 0;

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   task automatic probe_pair();
      logic [31:0] v;
      @(negedge clk); acc_valid = 1; acc_addr = 32'h7000_0000; acc_fetch = 1;
      @(negedge clk); acc_fetch = 0; acc_write = 1; acc_addr = 32'h0000_0100;
      @(negedge clk); acc_valid = 0; acc_write = 0;
      rd(4'd1, v); check(v == 32'h83, "R11 both flags sticky", v, 32'h83);
      rd(4'd2, v); check(v == 32'h7000_0000, "R12 first address kept", v, 32'h7000_0000);
      wr(4'd1, 32'h01);
      rd(4'd1, v); check(v == 32'h82, "R11 write one clears only bit 0", v, 32'h82);
      wr(4'd1, 32'h82);
      rd(4'd1, v); check(v == 0, "R11 cleared", v, 0);
      @(negedge clk); acc_valid = 1; acc_addr = 32'h6000_0000;
      @(negedge clk); acc_valid = 0;
      rd(4'd2, v); check(v == 32'h6000_0000, "R12 capture re-armed", v, 32'h6000_0000);
      wr(4'd1, 32'h83);
   endtask
endmodule